// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive side of an Ethernet MAC and decides, one frame at a time, whether the frame's 48-bit destination address is wanted. A frame parser presents the address with a one-cycle valid strobe. One clock later the filter returns a registered accept/reject decision with its own one-cycle valid pulse.

Four rules decide the result, in a fixed order. Promiscuous mode accepts everything. Otherwise the all-ones broadcast address is accepted only when broadcast reception is on. Any other address with the group bit set is treated as multicast: it is accepted when multicast reception is on and the bin that the address hashes to is set in a 64-bit table. An individual (unicast) address is accepted only when it equals the programmed station address.

Software programs the control word, the two 32-bit halves of the hash table and the station address through a simple write port. A separate combinational hash port returns the 6-bit bin index of any address, so that software or a test environment can compute which table bit to set for a group address. Loading both table halves with all ones makes every multicast frame pass.

Top module: `rx_dest_filter`

## Requirements
- R1: `hashIndex` is the 6-bit fold of `hashAddr`. Byte k of the address is `hashAddr[47-8k -: 8]`, so byte 0 is `hashAddr[47:40]`. Bytes 0 and 3 each give (b>>2)^(b<<4), bytes 1 and 4 each give (b>>4)^(b<<2), and bytes 2 and 5 each give (b>>6)^b. The six terms are XORed together starting from zero, and the low 6 bits of the result form the index.
- R2: A hash index n below 32 selects bit n of the low table word (register select 1). An index n of 32 or more selects bit n-32 of the high table word (register select 2).
- R3: When control bit 21 (promiscuous) is 1, every frame is accepted, whatever its address and whatever the other control bits are.
- R4: An address of all 48 ones is accepted exactly when control bit 13 (broadcast enable) is 1. The hash table plays no part, and such an address is never treated as multicast.
- R5: An address that is not a broadcast but has `dstAddr[40]` set (bit 0 of byte 0) is accepted exactly when control bit 5 (multicast enable) is 1 and its hash bin bit is 1.
- R6: An address with `dstAddr[40]` clear is accepted exactly when it equals the station address. The station address takes bits 31:0 from register select 3 and bits 47:32 from bits 15:0 of register select 4.
- R7: `resultValid` is high for exactly one cycle, on the clock after each cycle in which `addrValid` is high. Back-to-back frames give back-to-back results. `accept` is 0 whenever `resultValid` is 0.
- R8: After reset, `resultValid` and `accept` are 0. All control bits, both table words and the station address are also 0, so non-zero frames are rejected.
- R9: A write with `regWrEn` high loads register select 0 (control), 1, 2, 3 or 4 at the clock edge. A frame evaluated on a later cycle uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register select (0 control, 1 hash low, 2 hash high, 3 station low, 4 station high) |
| regWrData | input | 32 | Register write data |
| addrValid | input | 1 | Destination address present this cycle |
| dstAddr | input | 48 | Destination address, byte 0 in bits 47:40 |
| hashAddr | input | 48 | Address for the hash helper |
| hashIndex | output | 6 | Hash bin of `hashAddr` (combinational) |
| resultValid | output | 1 | Decision valid pulse |
| accept | output | 1 | Frame accepted (qualified by `resultValid`) |

## Verification
The bench looks for two addresses whose bins fall on either side of index 32, sets one bin at a time and sends both. A filter that swapped the table halves, or that indexed the high word without subtracting 32, would then accept the wrong frame. It also sends the broadcast address with broadcast reception off but the whole table set; a filter that checked the hash before the broadcast rule would wrongly accept it. Station matching is tested with a single differing bit in each half of the address, which catches a design that compares only one register. Back-to-back frames with opposite results catch a decision that lags or stretches by a cycle.

// File: rtl/dfilt_pkg.sv
package dfilt_pkg;
  localparam int MAC_BYTES = 6;
  localparam int MAC_W     = 8 * MAC_BYTES;
  localparam int REG_W     = 32;
  localparam int HASH_W    = 6;
  localparam int BINS      = 1 << HASH_W;
  localparam int SEL_W     = 3;

  localparam int PROMISC_BIT = 21;
  localparam int BCAST_BIT   = 13;
  localparam int MCAST_BIT   = 5;

  localparam logic [SEL_W-1:0] SEL_CTRL    = 3'd0;
  localparam logic [SEL_W-1:0] SEL_HASH_LO = 3'd1;
  localparam logic [SEL_W-1:0] SEL_HASH_HI = 3'd2;
  localparam logic [SEL_W-1:0] SEL_STA_LO  = 3'd3;
  localparam logic [SEL_W-1:0] SEL_STA_HI  = 3'd4;

  typedef struct packed {
    logic ldCtrl;
    logic ldHashLo;
    logic ldHashHi;
    logic ldStaLo;
    logic ldStaHi;
    logic evaluate;
  } ctlStrobe_t;
endpackage

// File: rtl/dfilt_hash_fold.sv
module dfilt_hash_fold
  import dfilt_pkg::*;
#(
  parameter int NBYTES = MAC_BYTES,
  parameter int IDX_W  = HASH_W
) (
  input  logic [8*NBYTES-1:0] addr,
  output logic [IDX_W-1:0]    index
);
  localparam int ACC_W = 16;

  logic [ACC_W-1:0] acc;

  always_comb begin
    acc = '0;
    for (int i = 0; i < NBYTES; i++) begin
      logic [ACC_W-1:0] b;
      b = {{(ACC_W-8){1'b0}}, addr[8*(NBYTES-1-i) +: 8]};
      case (i % 3)
        0:       acc = acc ^ ((b >> 2) ^ (b << 4));
        1:       acc = acc ^ ((b >> 4) ^ (b << 2));
        default: acc = acc ^ ((b >> 6) ^ b);
      endcase
    end
    index = acc[IDX_W-1:0];
  end
endmodule

// File: rtl/dfilt_ctrl.sv
module dfilt_ctrl
  import dfilt_pkg::*;
#(
  parameter int SW = SEL_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWrEn,
  input  logic [SW-1:0] regAddr,
  input  logic          addrValid,
  output ctlStrobe_t    strobe,
  output logic          resultValid
);
  always_comb begin
    strobe          = '0;
    strobe.evaluate = addrValid;
    if (regWrEn) begin
      case (regAddr)
        SEL_CTRL:    strobe.ldCtrl   = 1'b1;
        SEL_HASH_LO: strobe.ldHashLo = 1'b1;
        SEL_HASH_HI: strobe.ldHashHi = 1'b1;
        SEL_STA_LO:  strobe.ldStaLo  = 1'b1;
        SEL_STA_HI:  strobe.ldStaHi  = 1'b1;
        default:     ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resultValid <= 1'b0;
    else       resultValid <= addrValid;
  end
endmodule

// File: rtl/dfilt_datapath.sv
module dfilt_datapath
  import dfilt_pkg::*;
#(
  parameter int AW = MAC_W,
  parameter int DW = REG_W,
  parameter int IW = HASH_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobe_t    strobe,
  input  logic [DW-1:0] wrData,
  input  logic [AW-1:0] dstAddr,
  input  logic [AW-1:0] hashAddr,
  output logic [IW-1:0] hashIndex,
  output logic          accept
);
  localparam int NB    = 1 << IW;
  localparam int HALF  = NB / 2;
  localparam int HI_W  = AW - DW;
  localparam int GRP_BIT = AW - 8;

  logic          promiscEn, bcastEn, mcastEn;
  logic [NB-1:0] hashTbl;
  logic [AW-1:0] station;
  logic [IW-1:0] frameIdx;
  logic          isBcast, isGroup, binHit, staHit, decision;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      promiscEn <= 1'b0;
      bcastEn   <= 1'b0;
      mcastEn   <= 1'b0;
      hashTbl   <= '0;
      station   <= '0;
    end else begin
      if (strobe.ldCtrl) begin
        promiscEn <= wrData[PROMISC_BIT];
        bcastEn   <= wrData[BCAST_BIT];
        mcastEn   <= wrData[MCAST_BIT];
      end
      if (strobe.ldHashLo) hashTbl[HALF-1:0]   <= wrData[HALF-1:0];
      if (strobe.ldHashHi) hashTbl[NB-1:HALF]  <= wrData[HALF-1:0];
      if (strobe.ldStaLo)  station[DW-1:0]     <= wrData;
      if (strobe.ldStaHi)  station[AW-1:DW]    <= wrData[HI_W-1:0];
    end
  end

  dfilt_hash_fold #(.NBYTES(AW/8), .IDX_W(IW)) frameHash (
    .addr (dstAddr),
    .index(frameIdx)
  );

  dfilt_hash_fold #(.NBYTES(AW/8), .IDX_W(IW)) helperHash (
    .addr (hashAddr),
    .index(hashIndex)
  );

  always_comb begin
    isBcast = &dstAddr;
    isGroup = dstAddr[GRP_BIT];
    binHit  = hashTbl[frameIdx];
    staHit  = (dstAddr == station);
    if (promiscEn)    decision = 1'b1;
    else if (isBcast) decision = bcastEn;
    else if (isGroup) decision = mcastEn & binHit;
    else              decision = staHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               accept <= 1'b0;
    else if (strobe.evaluate) accept <= decision;
    else                     accept <= 1'b0;
  end
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import dfilt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [SEL_W-1:0]  regAddr,
  input  logic [REG_W-1:0]  regWrData,
  input  logic              addrValid,
  input  logic [MAC_W-1:0]  dstAddr,
  input  logic [MAC_W-1:0]  hashAddr,
  output logic [HASH_W-1:0] hashIndex,
  output logic              resultValid,
  output logic              accept
);
  ctlStrobe_t strobe;

  dfilt_ctrl #(.SW(SEL_W)) ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .addrValid  (addrValid),
    .strobe     (strobe),
    .resultValid(resultValid)
  );

  dfilt_datapath #(.AW(MAC_W), .DW(REG_W), .IW(HASH_W)) dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (regWrData),
    .dstAddr  (dstAddr),
    .hashAddr (hashAddr),
    .hashIndex(hashIndex),
    .accept   (accept)
  );
endmodule

// File: rtl/rx_dest_filter_checker.sv
module rx_dest_filter_checker
  import dfilt_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic [SEL_W-1:0] regAddr,
  input logic [REG_W-1:0] regWrData,
  input logic             addrValid,
  input logic [MAC_W-1:0] dstAddr,
  input logic             resultValid,
  input logic             accept
);
  logic shPromisc, shBcast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shPromisc <= 1'b0;
      shBcast   <= 1'b0;
    end else if (regWrEn && regAddr == SEL_CTRL) begin
      shPromisc <= regWrData[PROMISC_BIT];
      shBcast   <= regWrData[BCAST_BIT];
    end
  end

  // R7
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |=> resultValid);
  // R7
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !addrValid |=> !resultValid);
  // R7
  a_r7_accept_qualified: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> !accept);
  // R3
  a_r3_promisc_accepts: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && shPromisc && !regWrEn) |=> accept);
  // R4
  a_r4_bcast_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && !shPromisc && !shBcast && (&dstAddr) && !regWrEn) |=> !accept);
  // R8
  a_r8_reset_quiet: assert property (@(posedge clk)
    $rose(rstN) |-> (!resultValid && !accept));
endmodule

bind rx_dest_filter rx_dest_filter_checker chk (
  .clk        (clk),
  .rstN       (rstN),
  .regWrEn    (regWrEn),
  .regAddr    (regAddr),
  .regWrData  (regWrData),
  .addrValid  (addrValid),
  .dstAddr    (dstAddr),
  .resultValid(resultValid),
  .accept     (accept)
);

// File: tb/rx_dest_filter_test.sv
module rx_dest_filter_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic        addrValid = 1'b0;
  logic [47:0] dstAddr = '0;
  logic [47:0] hashAddr = '0;
  logic [5:0]  hashIndex;
  logic        resultValid;
  logic        accept;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  localparam logic [31:0] C_PROMISC = 32'h0020_0000;
  localparam logic [31:0] C_BCAST   = 32'h0000_2000;
  localparam logic [31:0] C_MCAST   = 32'h0000_0020;
  localparam logic [47:0] BCAST_ADDR = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] STATION    = 48'h0012_3456_789A;

  always #10 clk = ~clk;

  rx_dest_filter uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .addrValid(addrValid), .dstAddr(dstAddr),
    .hashAddr(hashAddr), .hashIndex(hashIndex),
    .resultValid(resultValid), .accept(accept)
  );

  function automatic int modelHash(logic [47:0] a);
    int h = 0;
    for (int i = 0; i < 6; i++) begin
      int b = int'(a[47-8*i -: 8]);
      case (i % 3)
        0: h = h ^ ((b >> 2) ^ (b << 4));
        1: h = h ^ ((b >> 4) ^ (b << 2));
        default: h = h ^ ((b >> 6) ^ b);
      endcase
    end
    return h & 63;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = sel; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic setHashBin(input int idx);
    logic [31:0] lo = '0, hi = '0;
    if (idx < 32) lo[idx] = 1'b1; else hi[idx-32] = 1'b1;
    writeReg(3'd1, lo);
    writeReg(3'd2, hi);
  endtask

  task automatic sendFrame(input logic [47:0] a, input bit exp, input string req);
    @(negedge clk);
    addrValid = 1'b1; dstAddr = a;
    @(negedge clk);
    addrValid = 1'b0;
    check(resultValid === 1'b1, "R7", longint'(resultValid), 1);
    check(accept === exp, req, longint'(accept), longint'(exp));
    @(negedge clk);
    check(resultValid === 1'b0 && accept === 1'b0, "R7", longint'({resultValid, accept}), 0);
  endtask

  task automatic testReset();
    check(resultValid === 1'b0, "R8", longint'(resultValid), 0);
    check(accept === 1'b0, "R8", longint'(accept), 0);
    sendFrame(48'h0200_0000_0001, 1'b0, "R8");
    sendFrame(BCAST_ADDR, 1'b0, "R8");
  endtask

  task automatic testHashHelper();
    logic [47:0] vec [4] = '{48'h0100_5E00_0001, 48'h3333_0000_00FB,
                             48'hA5C3_0F96_7E11, 48'hFFFF_FFFF_FFFF};
    for (int i = 0; i < 4; i++) begin
      hashAddr = vec[i];
      #1;
      check(int'(hashIndex) == modelHash(vec[i]), "R1", longint'(hashIndex),
            longint'(modelHash(vec[i])));
    end
  endtask

  task automatic testHashHalves();
    logic [47:0] loA = '0, hiA = '0;
    bit gotLo = 0, gotHi = 0;
    for (int k = 0; k < 256; k++) begin
      logic [47:0] c = {40'h0100_5E00_00, k[7:0]};
      if (!gotLo && modelHash(c) < 32) begin loA = c; gotLo = 1; end
      if (!gotHi && modelHash(c) >= 32) begin hiA = c; gotHi = 1; end
    end
    check(gotLo && gotHi, "R2", longint'({gotLo, gotHi}), 3);
    writeReg(3'd0, C_MCAST);
    setHashBin(modelHash(loA));
    sendFrame(loA, 1'b1, "R2");
    sendFrame(hiA, 1'b0, "R2");
    setHashBin(modelHash(hiA));
    sendFrame(hiA, 1'b1, "R2");
    sendFrame(loA, 1'b0, "R2");
  endtask

  task automatic testMulticast();
    writeReg(3'd1, 32'hFFFF_FFFF);
    writeReg(3'd2, 32'hFFFF_FFFF);
    writeReg(3'd0, 32'h0);
    sendFrame(48'h0100_5E7F_0001, 1'b0, "R5");
    writeReg(3'd0, C_MCAST);
    sendFrame(48'h0100_5E7F_0001, 1'b1, "R5");
    sendFrame(48'h3333_0000_0016, 1'b1, "R5");
    writeReg(3'd1, 32'h0);
    writeReg(3'd2, 32'h0);
    sendFrame(48'h3333_0000_0016, 1'b0, "R5");
  endtask

  task automatic testBroadcast();
    writeReg(3'd1, 32'hFFFF_FFFF);
    writeReg(3'd2, 32'hFFFF_FFFF);
    writeReg(3'd0, C_MCAST);
    sendFrame(BCAST_ADDR, 1'b0, "R4");
    writeReg(3'd1, 32'h0);
    writeReg(3'd2, 32'h0);
    writeReg(3'd0, C_BCAST);
    sendFrame(BCAST_ADDR, 1'b1, "R4");
  endtask

  task automatic testUnicast();
    writeReg(3'd3, STATION[31:0]);
    writeReg(3'd4, {16'h0, STATION[47:32]});
    writeReg(3'd0, 32'h0);
    sendFrame(STATION, 1'b1, "R6");
    sendFrame(STATION ^ 48'h0000_0000_0100, 1'b0, "R6");
    sendFrame(STATION ^ 48'h0004_0000_0000, 1'b0, "R6");
    writeReg(3'd4, 32'h0000_0099);
    sendFrame(STATION, 1'b0, "R9");
    sendFrame({16'h0099, STATION[31:0]}, 1'b1, "R9");
  endtask

  task automatic testPromisc();
    writeReg(3'd0, C_PROMISC);
    sendFrame(48'h0200_DEAD_BEEF, 1'b1, "R3");
    sendFrame(BCAST_ADDR, 1'b1, "R3");
    sendFrame(48'h0100_5E01_0203, 1'b1, "R3");
    writeReg(3'd0, 32'h0);
    sendFrame(48'h0200_DEAD_BEEF, 1'b0, "R3");
  endtask

  task automatic testBackToBack();
    writeReg(3'd0, C_BCAST);
    @(negedge clk);
    addrValid = 1'b1; dstAddr = BCAST_ADDR;
    @(negedge clk);
    dstAddr = 48'h0200_0000_0055;
    check(resultValid === 1'b1 && accept === 1'b1, "R7", longint'({resultValid, accept}), 3);
    @(negedge clk);
    addrValid = 1'b0;
    check(resultValid === 1'b1 && accept === 1'b0, "R7", longint'({resultValid, accept}), 2);
    @(negedge clk);
    check(resultValid === 1'b0, "R7", longint'(resultValid), 0);
  endtask

  task automatic finish();
    if (finished) return;
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testHashHelper();
    testHashHalves();
    testMulticast();
    testBroadcast();
    testUnicast();
    testPromisc();
    testBackToBack();
    finish();
  end
endmodule